// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial input into parallel characters. A 16x oversampling enable paces it, and that enable is separate from any transmit timing. The receiver looks for a falling edge on the line and checks it again halfway into the start bit. It then samples each following bit at its centre and rebuilds a character of 5 to 8 bits, least significant bit first. An optional parity bit follows, then the stop bit. Each finished character is stored together with three flags of its own: parity error, framing error and break.

Characters go into a queue of 16 entries. When queue mode is off, the block acts as a single holding register instead. A read strobe removes the oldest entry, whose fields are always visible on the read outputs. The block also reports three conditions: data ready (the queue is not empty), overrun (a character arrived while there was no room) and character timeout (in queue mode, data has waited a long time with no line or read activity).

Top module: `async_rx_queue`

## Requirements
- R1: After reset, dataReady, overrun and timeoutFlag are all 0.
- R2: charLen selects the data length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and appear on rdData right-aligned, with the unused upper bits at 0.
- R3: When parityEn is 1, one parity bit follows the data bits. parityOdd=1 selects odd parity and 0 selects even. rdParErr is 1 for a character whose parity bit does not match. When parityEn is 0, no parity bit is expected and rdParErr is 0.
- R4: rdFrmErr is 1 for a character whose stop bit samples low.
- R5: rdBrk is 1 when every data bit, the parity bit (if enabled) and the stop bit all sample low. Such an entry has rdData=0 and rdFrmErr=1. After a break, the receiver waits for the line to go high before it looks for a new start, so a held-low line yields exactly one entry.
- R6: A falling edge on serIn that is no longer low at the 8th oversampling tick is discarded, and no entry is stored.
- R7: With fifoEn=1, up to 16 characters are held and read back in arrival order, each with its own error flags.
- R8: If a character completes when the queue has no room and no read happens in the same cycle, overrun goes to 1 and the new character is dropped. The stored entries are unchanged. A read strobe clears overrun.
- R9: With fifoEn=0, the capacity is one entry, so a second unread character causes overrun and the first character stays readable.
- R10: dataReady is 1 exactly when at least one entry is stored. A read strobe while empty has no effect.
- R11: With fifoEn=1, timeoutFlag goes to 1 once an entry has waited 4 character times with no new character and no read. One character time is (1 + data bits + parity bit + 1) x 16 ticks. A read or a new character clears the flag. With fifoEn=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| serIn | input | 1 | Serial line, idle high |
| charLen | input | 2 | Data length code (0..3 gives 5..8 bits) |
| parityEn | input | 1 | Expect a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| fifoEn | input | 1 | 1 selects the 16-entry queue, 0 selects the single register |
| popReq | input | 1 | Read strobe; removes the oldest entry |
| rdData | output | 8 | Data of the oldest entry |
| rdParErr | output | 1 | Parity error flag of the oldest entry |
| rdFrmErr | output | 1 | Framing error flag of the oldest entry |
| rdBrk | output | 1 | Break flag of the oldest entry |
| dataReady | output | 1 | At least one entry is stored |
| overrun | output | 1 | A character was dropped for lack of room |
| timeoutFlag | output | 1 | Stored data has been idle for 4 character times |

## Verification
The hardest situation to reach is a break followed by a line that stays low. If the receiver did not wait for the line to go high, it would quietly stack up extra break entries. The stimulus holds the line low for several bit times after a break frame. It then reads once and confirms that the queue is empty. Overrun is reached by sending 17 frames with no reads in between. The timeout is reached by leaving one entry unread for more than four character times, and by checking both sides of that limit.

// File: rtl/arx_pkg.sv
package arx_pkg;

  // Strobes from the line sequencer to the datapath
  typedef struct packed {
    logic startChar;  // start bit confirmed at its centre
    logic dataBit;    // centre sample of a data bit
    logic parBit;     // centre sample of the parity bit
    logic finish;     // centre sample of the stop bit
    logic val;        // synchronised line value at the sample
  } rxStrobe_t;

  // One stored character with its error tags
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxEntry_t;

endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       serIn,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  output rxStrobe_t  strobe
);
  localparam int SW = $clog2(OS);
  localparam logic [SW-1:0] MID  = SW'(OS / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OS - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, HOLD} rxState_t;

  rxState_t      state;
  logic [1:0]    syncQ;
  logic [SW-1:0] subCnt;
  logic [2:0]    bitCnt;
  logic          allLow;
  logic          rxS;
  logic          sampleNow;
  logic [2:0]    lastBit;

  assign rxS       = syncQ[1];
  assign sampleNow = tick16 && (subCnt == LAST);
  assign lastBit   = {1'b0, charLen} + 3'd4;

  always_comb begin
    strobe           = '0;
    strobe.val       = rxS;
    strobe.startChar = (state == START) && tick16 && (subCnt == MID) && !rxS;
    strobe.dataBit   = (state == DATA) && sampleNow;
    strobe.parBit    = (state == PAR) && sampleNow;
    strobe.finish    = (state == STOP) && sampleNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      state  <= IDLE;
      subCnt <= '0;
      bitCnt <= '0;
      allLow <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], serIn};
      unique case (state)
        IDLE: if (tick16 && !rxS) begin
          state  <= START;
          subCnt <= '0;
        end
        START: if (tick16) begin
          if (subCnt == MID) begin
            subCnt <= '0;
            bitCnt <= '0;
            allLow <= 1'b1;
            state  <= rxS ? IDLE : DATA;
          end else begin
            subCnt <= subCnt + 1'b1;
          end
        end
        DATA: if (tick16) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) begin
            allLow <= allLow & !rxS;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == lastBit) state <= parityEn ? PAR : STOP;
          end
        end
        PAR: if (tick16) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) begin
            allLow <= allLow & !rxS;
            state  <= STOP;
          end
        end
        STOP: if (tick16) begin
          subCnt <= subCnt + 1'b1;
          if (subCnt == LAST) state <= (allLow && !rxS) ? HOLD : IDLE;
        end
        HOLD: if (rxS) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arx_dpath.sv
module arx_dpath
  import arx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OS       = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  rxStrobe_t  strobe,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       fifoEn,
  input  logic       popReq,
  output rxEntry_t   head,
  output logic       dataReady,
  output logic       overrun,
  output logic       timeoutFlag
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int TW = $clog2(TO_CHARS * 12 * OS + 1);

  logic [7:0]    shReg;
  logic          parSeen;
  logic          anyHigh;
  logic [7:0]    aligned;
  rxEntry_t      newEntry;
  rxEntry_t      mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count, cap;
  logic          full, doPop, doPush;
  logic [TW-1:0] toCnt, limit;

  // Character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      parSeen <= 1'b0;
      anyHigh <= 1'b0;
    end else if (strobe.startChar) begin
      shReg   <= '0;
      parSeen <= 1'b0;
      anyHigh <= 1'b0;
    end else if (strobe.dataBit) begin
      shReg   <= {strobe.val, shReg[7:1]};
      anyHigh <= anyHigh | strobe.val;
    end else if (strobe.parBit) begin
      parSeen <= strobe.val;
      anyHigh <= anyHigh | strobe.val;
    end
  end

  always_comb begin
    aligned       = shReg >> (3'd3 - {1'b0, charLen});
    newEntry.data = aligned;
    newEntry.par  = parityEn & ((^aligned) ^ parSeen ^ parityOdd);
    newEntry.frm  = !strobe.val;
    newEntry.brk  = !anyHigh && !strobe.val;
  end

  // Queue
  assign cap       = fifoEn ? CW'(DEPTH) : CW'(1);
  assign full      = (count >= cap);
  assign doPop     = popReq && (count != '0);
  assign doPush    = strobe.finish && (!full || doPop);
  assign dataReady = (count != '0);
  assign head      = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
      if (strobe.finish && full && !doPop) overrun <= 1'b1;
      else if (popReq)                      overrun <= 1'b0;
    end
  end

  // Character timeout
  assign limit = TW'(TO_CHARS) * TW'(OS) *
                 (TW'(charLen) + TW'(7) + TW'(parityEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toCnt       <= '0;
      timeoutFlag <= 1'b0;
    end else if (doPush || doPop || count == '0 || !fifoEn) begin
      toCnt       <= '0;
      timeoutFlag <= 1'b0;
    end else if (tick16 && !timeoutFlag) begin
      if (toCnt == limit - 1'b1) timeoutFlag <= 1'b1;
      else                       toCnt <= toCnt + 1'b1;
    end
  end
endmodule

// File: rtl/async_rx_queue.sv
module async_rx_queue
  import arx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OS       = 16,
  parameter int TO_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       serIn,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       fifoEn,
  input  logic       popReq,
  output logic [7:0] rdData,
  output logic       rdParErr,
  output logic       rdFrmErr,
  output logic       rdBrk,
  output logic       dataReady,
  output logic       overrun,
  output logic       timeoutFlag
);
  rxStrobe_t strobe;
  rxEntry_t  head;

  arx_ctrl #(.OS(OS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serIn(serIn),
    .charLen(charLen), .parityEn(parityEn), .strobe(strobe)
  );

  arx_dpath #(.DEPTH(DEPTH), .OS(OS), .TO_CHARS(TO_CHARS)) dpath_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .strobe(strobe),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .fifoEn(fifoEn), .popReq(popReq), .head(head),
    .dataReady(dataReady), .overrun(overrun), .timeoutFlag(timeoutFlag)
  );

  assign rdData   = head.data;
  assign rdParErr = head.par;
  assign rdFrmErr = head.frm;
  assign rdBrk    = head.brk;
endmodule

// File: rtl/arx_checker.sv
module arx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       popReq,
  input logic       dataReady,
  input logic       overrun,
  input logic       timeoutFlag,
  input logic [7:0] rdData,
  input logic       rdFrmErr,
  input logic       rdBrk
);
  // Data only leaves the queue through a read
  assert_ready_drop_needs_read_R10: assert property (
    @(posedge clk) disable iff (!rstN) $fell(dataReady) |-> $past(popReq));

  // Overrun can only start while something is already stored
  assert_overrun_when_occupied_R8: assert property (
    @(posedge clk) disable iff (!rstN) $rose(overrun) |-> $past(dataReady));

  // A timeout always refers to stored data
  assert_timeout_has_data_R11: assert property (
    @(posedge clk) disable iff (!rstN) timeoutFlag |-> dataReady);

  // A break entry carries zero data and a framing error
  assert_break_shape_R5: assert property (
    @(posedge clk) disable iff (!rstN)
      (dataReady && rdBrk) |-> (rdData == 8'h00 && rdFrmErr));
endmodule

bind async_rx_queue arx_checker chk_i (
  .clk(clk), .rstN(rstN), .popReq(popReq), .dataReady(dataReady),
  .overrun(overrun), .timeoutFlag(timeoutFlag), .rdData(rdData),
  .rdFrmErr(rdFrmErr), .rdBrk(rdBrk)
);

// File: tb/async_rx_queue_tb.sv
module async_rx_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32;  // 16 ticks, one tick every 2 clocks
  localparam int NVEC       = 6;

  typedef struct packed {
    logic [1:0] len;
    logic       pEn;
    logic       pOdd;
    logic [7:0] data;
    logic       flipPar;
    logic       stopVal;
    logic [3:0] holdLow;
    logic [7:0] expData;
    logic       expPar;
    logic       expFrm;
    logic       expBrk;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 4'd0, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 8'h35, 1'b0, 1'b1, 4'd0, 8'h15, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 8'h41, 1'b0, 1'b1, 4'd0, 8'h41, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 8'h41, 1'b1, 1'b1, 4'd0, 8'h41, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 4'd0, 8'h2A, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd3, 8'h00, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic serIn = 1'b1;
  logic [1:0] charLen = 2'd3;
  logic parityEn = 1'b0;
  logic parityOdd = 1'b0;
  logic fifoEn = 1'b1;
  logic popReq = 1'b0;
  logic [7:0] rdData;
  logic rdParErr, rdFrmErr, rdBrk, dataReady, overrun, timeoutFlag;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  async_rx_queue dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .serIn(serIn),
    .charLen(charLen), .parityEn(parityEn), .parityOdd(parityOdd),
    .fifoEn(fifoEn), .popReq(popReq), .rdData(rdData),
    .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdBrk(rdBrk),
    .dataReady(dataReady), .overrun(overrun), .timeoutFlag(timeoutFlag)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tick16 = ~tick16;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nBits, input bit usePar,
                           input bit parVal, input bit stopVal, input int holdLow);
    serIn = 1'b0; waitClk(BIT_CLKS);
    for (int i = 0; i < nBits; i++) begin
      serIn = d[i]; waitClk(BIT_CLKS);
    end
    if (usePar) begin
      serIn = parVal; waitClk(BIT_CLKS);
    end
    serIn = stopVal; waitClk(BIT_CLKS);
    if (holdLow > 0) begin
      serIn = 1'b0; waitClk(holdLow * BIT_CLKS);
    end
    serIn = 1'b1; waitClk(BIT_CLKS);
  endtask

  task automatic send8(input logic [7:0] d);
    sendFrame(d, 8, 1'b0, 1'b0, 1'b1, 0);
  endtask

  task automatic pop();
    popReq = 1'b1; waitClk(1);
    popReq = 1'b0; waitClk(1);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    waitClk(150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    waitClk(4);
    // R1: reset state
    check(dataReady == 0, "R1 dataReady", dataReady, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);
    check(timeoutFlag == 0, "R1 timeout", timeoutFlag, 0);
    rstN = 1'b1;
    waitClk(40);

    // Table walk: R2 lengths, R3 parity, R4 framing, R5 break
    foreach (VECS[k]) begin
      vec_t v = VECS[k];
      logic [7:0] m;
      bit pv;
      int n;
      n  = 5 + int'(v.len);
      m  = 8'hFF >> (8 - n);
      pv = (^(v.data & m)) ^ v.pOdd ^ v.flipPar;
      charLen = v.len; parityEn = v.pEn; parityOdd = v.pOdd;
      waitClk(4);
      sendFrame(v.data, n, v.pEn, pv, v.stopVal, int'(v.holdLow));
      waitClk(8);
      check(dataReady == 1, "R10 ready after frame", dataReady, 1);
      check(rdData == v.expData, "R2 data", rdData, v.expData);
      check(rdParErr == v.expPar, "R3 parity flag", rdParErr, v.expPar);
      check(rdFrmErr == v.expFrm, "R4 framing flag", rdFrmErr, v.expFrm);
      check(rdBrk == v.expBrk, "R5 break flag", rdBrk, v.expBrk);
      pop();
      check(dataReady == 0, "R5 single entry per frame", dataReady, 0);
    end

    // R6: false start glitch
    charLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;
    serIn = 1'b0; waitClk(6);
    serIn = 1'b1; waitClk(400);
    check(dataReady == 0, "R6 false start dropped", dataReady, 0);

    // R10: read while empty has no effect
    pop();
    check(dataReady == 0 && overrun == 0, "R10 empty read", {dataReady, overrun}, 0);

    // R7 and R8: fill the queue, then overflow it
    for (int i = 0; i < 16; i++) send8(8'(i * 3 + 1));
    check(overrun == 0, "R7 sixteen fit", overrun, 0);
    send8(8'hEE);
    waitClk(4);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    for (int i = 0; i < 16; i++) begin
      check(rdData == 8'(i * 3 + 1), "R7 order", rdData, i * 3 + 1);
      pop();
      if (i == 0) check(overrun == 0, "R8 overrun cleared by read", overrun, 0);
    end
    check(dataReady == 0, "R8 extra char discarded", dataReady, 0);

    // R11: timeout in queue mode
    send8(8'h5A);
    waitClk(600);
    check(timeoutFlag == 0, "R11 no early timeout", timeoutFlag, 0);
    waitClk(900);
    check(timeoutFlag == 1, "R11 timeout raised", timeoutFlag, 1);
    pop();
    check(timeoutFlag == 0 && dataReady == 0, "R11 read clears",
          {timeoutFlag, dataReady}, 0);

    // R9: single register mode
    fifoEn = 1'b0;
    waitClk(4);
    send8(8'h11);
    waitClk(1500);
    check(timeoutFlag == 0, "R11 no timeout without queue", timeoutFlag, 0);
    send8(8'h22);
    waitClk(4);
    check(overrun == 1, "R9 second char overruns", overrun, 1);
    check(rdData == 8'h11, "R9 first char kept", rdData, 8'h11);
    pop();
    check(dataReady == 0, "R9 capacity one", dataReady, 0);

    finishRun();
  end
endmodule